// File: doc/BRIEF.md
# Dual-Organisation Distributed RAM Cell

This block is a single 64-bit storage cell of the kind found in a logic cluster. A static organisation input sets it up either as 64 words of one bit or as 32 words of two bits. It has one write port and one read port. Writes take effect on the rising clock edge. Reads are combinational. The cell drives two output bits. The high output carries the addressed word, or the upper bit of a two-bit word. The low output always carries a location from the lower half of the array.

The write address port is eight bits wide. Only its low six bits reach the array. The cluster above decodes the top two bits into a write-qualify signal, and the cell takes that signal as an input. A static share input lets the write address also act as the read address, which gives a single-port configuration. With share low, the read address comes from its own port, which gives a dual-port configuration. A synchronous reset blocks writes while it is high. It does not clear the stored contents.

Top module: `lutram_cell`

## Requirements
- R1: With org_i = 0 (64x1), a rising edge with wr_en_i = 1, wr_qual_i = 1 and rst_i = 0 stores wr_data_i[0] at entry wr_addr_i[5:0]. wr_data_i[1] has no effect.
- R2: With org_i = 1 (32x2), such an edge stores wr_data_i[1] at entry 32 + wr_addr_i[4:0] and wr_data_i[0] at entry wr_addr_i[4:0], both in the same cycle. wr_addr_i[5] has no effect.
- R3: With org_i = 0, rd_hi_o equals entry A and rd_lo_o equals entry A[4:0], where A is the effective 6-bit read address.
- R4: With org_i = 1, rd_hi_o equals entry 32 + A[4:0] and rd_lo_o equals entry A[4:0]. A[5] has no effect.
- R5: No entry changes on an edge where wr_en_i = 0 or wr_qual_i = 0. wr_addr_i[7:6] never selects an entry.
- R6: With share_i = 1, the effective read address is wr_addr_i[5:0] and rd_addr_i has no effect. With share_i = 0, the effective read address is rd_addr_i.
- R7: When a location is written while it is being read, the outputs show the old contents until the edge and the new contents after it. There is no added delay.
- R8: While rst_i = 1, no write takes place. Contents written before reset are still there after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_i | input | 1 | Synchronous active-high reset; blocks writes |
| org_i | input | 1 | Static organisation: 0 = 64x1, 1 = 32x2 |
| share_i | input | 1 | Static: 1 = read address taken from write address |
| wr_en_i | input | 1 | Write enable |
| wr_qual_i | input | 1 | Write qualify from cluster-level address decode |
| wr_addr_i | input | 8 | Write address; bits 7:6 are not decoded here |
| rd_addr_i | input | 6 | Read address |
| wr_data_i | input | 2 | Write data |
| rd_hi_o | output | 1 | Upper / full-address read bit |
| rd_lo_o | output | 1 | Lower-half read bit |

## Verification
A write and a combinational read of the same location can fall in the same cycle. The bench provokes this by holding the read address, or the shared write address, on a location and then driving inverted data with the write enable high. It samples the outputs after the inputs settle but before the rising edge, and expects the old value. It samples again just after the edge and expects the new value. The mode sweeps also read every address in both organisations after each phase of writes, which checks how the two-bit words map onto the 64-entry array.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

  localparam int unsigned LR_ENTRY_LOG2 = 6;
  localparam int unsigned LR_WADDR_W    = 8;
  localparam int unsigned LR_DATA_W     = 2;

  typedef enum logic {
    ORG_WIDE1 = 1'b0,
    ORG_PAIR2 = 1'b1
  } org_e;

endpackage

// File: rtl/lutram_rd_sel.sv
module lutram_rd_sel #(
  parameter int unsigned AW  = 6,
  parameter int unsigned WAW = 8
) (
  input  logic           share_i,
  input  logic [WAW-1:0] wr_addr_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [AW-1:0]  eff_addr_o
);

  always_comb begin
    if (share_i) eff_addr_o = wr_addr_i[AW-1:0];
    else         eff_addr_o = rd_addr_i;
  end

endmodule

// File: rtl/lutram_wr_dec.sv
module lutram_wr_dec
  import lutram_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned WAW   = 8,
  parameter int unsigned DW    = 2,
  localparam int unsigned BAW  = AW - 1
) (
  input  logic           rst_i,
  input  logic           org_i,
  input  logic           wr_en_i,
  input  logic           wr_qual_i,
  input  logic [WAW-1:0] wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic [DW-1:0]  bank_we_o,
  output logic [BAW-1:0] bank_addr_o,
  output logic [DW-1:0]  bank_din_o
);

  logic fire;

  assign fire        = wr_en_i & wr_qual_i & ~rst_i;
  assign bank_addr_o = wr_addr_i[BAW-1:0];

  for (genvar g = 0; g < DW; g++) begin : g_bank
    always_comb begin
      if (org_e'(org_i) == ORG_PAIR2) begin
        bank_we_o[g]  = fire;
        bank_din_o[g] = wr_data_i[g];
      end else begin
        bank_we_o[g]  = fire & (wr_addr_i[AW-1] == g[0]);
        bank_din_o[g] = wr_data_i[0];
      end
    end
  end

endmodule

// File: rtl/lutram_bank.sv
module lutram_bank #(
  parameter int unsigned BAW   = 5,
  localparam int unsigned DEPTH = 1 << BAW
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [BAW-1:0] waddr_i,
  input  logic           din_i,
  input  logic [BAW-1:0] raddr_i,
  output logic           dout_o
);

  logic mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= din_i;
  end

  assign dout_o = mem[raddr_i];

endmodule

// File: rtl/lutram_cell.sv
module lutram_cell
  import lutram_pkg::*;
#(
  parameter int unsigned AW  = LR_ENTRY_LOG2,
  parameter int unsigned WAW = LR_WADDR_W,
  parameter int unsigned DW  = LR_DATA_W,
  localparam int unsigned BAW = AW - 1
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           org_i,
  input  logic           share_i,
  input  logic           wr_en_i,
  input  logic           wr_qual_i,
  input  logic [WAW-1:0] wr_addr_i,
  input  logic [AW-1:0]  rd_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic           rd_hi_o,
  output logic           rd_lo_o
);

  logic [AW-1:0]  eff_addr;
  logic [DW-1:0]  bank_we;
  logic [BAW-1:0] bank_addr;
  logic [DW-1:0]  bank_din;
  logic [DW-1:0]  bank_dout;

  lutram_rd_sel #(.AW(AW), .WAW(WAW)) u_rsel (
    .share_i   (share_i),
    .wr_addr_i (wr_addr_i),
    .rd_addr_i (rd_addr_i),
    .eff_addr_o(eff_addr)
  );

  lutram_wr_dec #(.AW(AW), .WAW(WAW), .DW(DW)) u_wdec (
    .rst_i      (rst_i),
    .org_i      (org_i),
    .wr_en_i    (wr_en_i),
    .wr_qual_i  (wr_qual_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .bank_we_o  (bank_we),
    .bank_addr_o(bank_addr),
    .bank_din_o (bank_din)
  );

  for (genvar g = 0; g < DW; g++) begin : g_bank
    lutram_bank #(.BAW(BAW)) u_bank (
      .clk_i  (clk_i),
      .we_i   (bank_we[g]),
      .waddr_i(bank_addr),
      .din_i  (bank_din[g]),
      .raddr_i(eff_addr[BAW-1:0]),
      .dout_o (bank_dout[g])
    );
  end

  always_comb begin
    rd_lo_o = bank_dout[0];
    if (org_e'(org_i) == ORG_WIDE1 && !eff_addr[AW-1]) rd_hi_o = bank_dout[0];
    else                                                rd_hi_o = bank_dout[1];
  end

endmodule

// File: rtl/lutram_cell_chk.sv
module lutram_cell_chk #(
  parameter int unsigned AW  = 6,
  parameter int unsigned WAW = 8,
  parameter int unsigned DW  = 2
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic           org_i,
  input logic           share_i,
  input logic           wr_en_i,
  input logic           wr_qual_i,
  input logic [WAW-1:0] wr_addr_i,
  input logic [AW-1:0]  rd_addr_i,
  input logic [DW-1:0]  wr_data_i,
  input logic           rd_hi_o,
  input logic           rd_lo_o
);

  logic          fire;
  logic [AW-1:0] ra;

  assign fire = wr_en_i & wr_qual_i & ~rst_i;
  assign ra   = share_i ? wr_addr_i[AW-1:0] : rd_addr_i;

  // R1: a 64x1 write is visible at the full address on the next cycle
  assert_wide_write_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(fire && !org_i) && !org_i && ra == $past(wr_addr_i[AW-1:0]))
      |-> rd_hi_o == $past(wr_data_i[0]));

  // R2: a 32x2 write lands both bits at once
  assert_pair_write_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(fire && org_i) && org_i && ra[AW-2:0] == $past(wr_addr_i[AW-2:0]))
      |-> (rd_hi_o == $past(wr_data_i[1]) && rd_lo_o == $past(wr_data_i[0])));

  // R3: low output of 64x1 reads the lower half at A[4:0]
  assert_wide_lo_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(fire && !org_i && !wr_addr_i[AW-1]) && !org_i &&
     ra[AW-2:0] == $past(wr_addr_i[AW-2:0]))
      |-> rd_lo_o == $past(wr_data_i[0]));

  // R5: without a qualified write and with steady read inputs, outputs hold
  assert_no_write_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(fire) && $stable(ra) && $stable(org_i))
      |-> ($stable(rd_hi_o) && $stable(rd_lo_o)));

endmodule

bind lutram_cell lutram_cell_chk #(.AW(AW), .WAW(WAW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .org_i    (org_i),
  .share_i  (share_i),
  .wr_en_i  (wr_en_i),
  .wr_qual_i(wr_qual_i),
  .wr_addr_i(wr_addr_i),
  .rd_addr_i(rd_addr_i),
  .wr_data_i(wr_data_i),
  .rd_hi_o  (rd_hi_o),
  .rd_lo_o  (rd_lo_o)
);

// File: tb/sim_lutram_cell.sv
`timescale 1ns/1ps
module sim_lutram_cell;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       org = 1'b0;
  logic       share = 1'b0;
  logic       we = 1'b0;
  logic       qual = 1'b0;
  logic [7:0] wa = '0;
  logic [5:0] ra = '0;
  logic [1:0] wd = '0;
  logic       hi, lo;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  model [64];

  always #5 clk = ~clk;

  lutram_cell u0 (
    .clk_i(clk), .rst_i(rst), .org_i(org), .share_i(share),
    .wr_en_i(we), .wr_qual_i(qual), .wr_addr_i(wa), .rd_addr_i(ra),
    .wr_data_i(wd), .rd_hi_o(hi), .rd_lo_o(lo)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (org=%0b share=%0b wa=%0h ra=%0h)",
               req, got, exp, org, share, wa, ra);
    end
  endtask

  task automatic do_write(input logic o, input logic e, input logic q,
                          input logic [7:0] a, input logic [1:0] d);
    @(negedge clk);
    org = o; we = e; qual = q; wa = a; wd = d;
    @(posedge clk);
    if (e && q && !rst) begin
      if (o) begin
        model[32 + a[4:0]] = d[1];
        model[a[4:0]]      = d[0];
      end else begin
        model[a[5:0]] = d[0];
      end
    end
    #1 we = 1'b0;
  endtask

  task automatic read_check(input logic o, input logic s, input logic [5:0] r,
                            input logic [7:0] a, input string req);
    logic [5:0] eff;
    @(negedge clk);
    org = o; share = s; ra = r; wa = a; we = 1'b0;
    #1;
    eff = s ? a[5:0] : r;
    if (o) begin
      chk(hi, model[32 + eff[4:0]], req);
      chk(lo, model[eff[4:0]], req);
    end else begin
      chk(hi, model[eff], req);
      chk(lo, model[eff[4:0]], req);
    end
  endtask

  function automatic logic pat(input int a, input int k);
    return logic'(((a * 37 + k * 11 + 5) >> 2) & 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: fill in 64x1, bit 1 of data and wa[7:6] vary but must not matter
    for (int a = 0; a < 64; a++)
      do_write(1'b0, 1'b1, 1'b1, {2'(a), 6'(a)}, {~pat(a, 0), pat(a, 0)});
    // R3 / R1: read every address in 64x1
    for (int a = 0; a < 64; a++) read_check(1'b0, 1'b0, 6'(a), 8'h00, "R3");
    // R4: same contents seen as 32x2, including A[5] set
    for (int a = 0; a < 64; a++) read_check(1'b1, 1'b0, 6'(a), 8'h00, "R4");

    // R2: 32x2 writes with wa[5] toggled
    for (int a = 0; a < 32; a++)
      do_write(1'b1, 1'b1, 1'b1, {2'b10, 1'(a), 5'(a)}, {pat(a, 1), pat(a, 2)});
    for (int a = 0; a < 64; a++) read_check(1'b1, 1'b0, 6'(a), 8'h00, "R2");
    for (int a = 0; a < 64; a++) read_check(1'b0, 1'b0, 6'(a), 8'h00, "R2");

    // R5: unqualified or disabled writes change nothing
    for (int a = 0; a < 64; a++) begin
      do_write(1'(a & 1), 1'b0, 1'b1, {2'b11, 6'(a)}, 2'b11 ^ {model[a], model[a]});
      do_write(1'(a & 1), 1'b1, 1'b0, {2'b01, 6'(a)}, 2'b11 ^ {model[a], model[a]});
    end
    for (int a = 0; a < 64; a++) read_check(1'b0, 1'b0, 6'(a), 8'h00, "R5");

    // R6: shared address, rd_addr driven with unrelated values
    for (int a = 0; a < 64; a++) read_check(1'b0, 1'b1, 6'(63 - a), {2'b10, 6'(a)}, "R6");
    for (int a = 0; a < 64; a++) read_check(1'b1, 1'b1, 6'(a ^ 21), {2'b00, 6'(a)}, "R6");

    // R7: read-during-write, dual-port then shared, both organisations
    for (int k = 0; k < 4; k++) begin
      logic o, s;
      logic [5:0] loc;
      logic old_v, new_v;
      o = 1'(k & 1); s = 1'(k >> 1); loc = 6'(9 + k * 13);
      @(negedge clk);
      org = o; share = s; ra = loc; wa = {2'b00, loc};
      new_v = ~model[o ? (32 + loc[4:0]) : loc];
      old_v = model[o ? (32 + loc[4:0]) : loc];
      wd = {new_v, new_v}; we = 1'b1; qual = 1'b1;
      #2 chk(hi, old_v, "R7");
      @(posedge clk);
      if (o) begin model[32 + loc[4:0]] = new_v; model[loc[4:0]] = new_v; end
      else model[loc] = new_v;
      #1 chk(hi, new_v, "R7");
      we = 1'b0;
    end

    // R8: writes blocked during reset, contents kept afterwards
    @(negedge clk) rst = 1'b1;
    for (int a = 0; a < 64; a++)
      do_write(1'b0, 1'b1, 1'b1, {2'b00, 6'(a)}, {~model[a], ~model[a]});
    @(negedge clk) rst = 1'b0;
    for (int a = 0; a < 64; a++) read_check(1'b0, 1'b0, 6'(a), 8'h00, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule